// File: doc/BRIEF.md
# Split-Address Microprogram Sequencer

This block steps through a microprogram written for control algorithms that are mostly straight-line. Each microinstruction address has two fields. The upper field is a chain number held in a register. The lower field is a position within that chain, held in a small counter. While the sequencer is inside a chain, it only advances the counter. It evaluates branch conditions only at the last microinstruction of a chain. At that point a small prioritised rule table loads both fields at once.

A control word holds the data-path micro-operation bits plus two sequencing bits: a step bit and an end bit. A start pulse points the sequencer at address zero and raises the fetch status. The end bit drops the fetch status and parks the unit until the next start. If a chain exit matches none of the rules, the unit raises an error flag and freezes.

Top module: `cmcu_seq`

## Requirements
- R1: While reset is low, and after it, fetch, err and uops are all 0, and they stay 0 until start is sampled high.
- R2: start sampled high on a clock edge loads chain 0 and offset 0, sets fetch and clears err, whatever the current state. In the following cycle, uops shows the word stored at address 0. Holding start high keeps re-entering address 0.
- R3: If the current word has step bit 1 and end bit 0, the next edge increments the offset and keeps the chain. The next word shown is the one at address {chain, offset+1}.
- R4: If the current word has step bit 0 and end bit 0, the next edge loads chain and offset together from the target of the matching rule. A rule matches when its chain field equals the current chain and (cond & mask) == (value & mask). The target may have a nonzero offset.
- R5: When several rules match, the rule with the lowest index wins.
- R6: If the current word has end bit 1, its micro-operations are still shown in that cycle, and fetch is 0 from the next cycle on until start.
- R7: uops is all zeros in every cycle where fetch is 0.
- R8: A chain exit that matches no rule sets err in the next cycle and clears fetch. err and the address then hold until start.
- R9: The address is {chain (upper CHAIN_W bits), offset (lower OFS_W bits)}. The word layout is {end, step, y[NY:1]} with y1 in bit 0. The store is read synchronously, so a word appears one edge after its address is chosen.
- R10: cond has no effect on an edge where the current word has step bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin the microprogram at address 0 |
| cond | input | NX | Logical condition inputs used at chain exits |
| fetch | output | 1 | High while microinstructions are being executed |
| err | output | 1 | High after a chain exit matched no rule |
| uops | output | NY | Data-path micro-operations, gated by fetch |

## Verification
The sample program includes several cases aimed at common faults.

- Exits that jump into the middle of a chain: a design that cleared the offset on every jump would show the wrong word after the jump.
- Two rules matching the same exit: reversing the priority sends the run into a different chain.
- Condition changes inside a chain: the bench changes cond mid-chain, so a design that branched on every edge would leave the chain early.
- Stop timing: the cycle after the end word is checked, so an off-by-one fetch drop, or micro-operations leaking while idle, shows up there.
- A deliberately unmatched exit: this shows whether err sticks, whether the address holds, and whether a later start clears the error.

// File: rtl/cmcu_pkg.sv
package cmcu_pkg;

  localparam int DEF_CHAIN_W = 3;
  localparam int DEF_OFS_W   = 2;
  localparam int DEF_NX      = 4;
  localparam int DEF_NY      = 8;
  localparam int DEF_NRULE   = 7;
  localparam int DEF_ADDR_W  = DEF_CHAIN_W + DEF_OFS_W;
  localparam int DEF_WORD_W  = DEF_NY + 2;
  localparam int DEF_DEPTH   = 1 << DEF_ADDR_W;
  localparam int DEF_RULE_W  = DEF_CHAIN_W + 2 * DEF_NX + DEF_ADDR_W;

  // sequencing action chosen for the current word
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_JUMP = 2'd2,
    ACT_TRAP = 2'd3
  } act_e;

  function automatic logic [DEF_WORD_W-1:0] mword(logic fin, logic stp, logic [DEF_NY-1:0] y);
    return {fin, stp, y};
  endfunction

  // sample microprogram: five chains, address = chain*4 + offset
  function automatic logic [DEF_DEPTH*DEF_WORD_W-1:0] def_store();
    logic [DEF_DEPTH*DEF_WORD_W-1:0] s;
    s = '0;
    s[ 0*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h01);
    s[ 1*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h02);
    s[ 2*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b0, 8'h03);
    s[ 4*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h10);
    s[ 5*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h11);
    s[ 6*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h12);
    s[ 7*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b0, 8'h13);
    s[ 8*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h20);
    s[ 9*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b0, 8'h21);
    s[12*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h30);
    s[13*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h31);
    s[14*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b0, 8'h32);
    s[16*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h40);
    s[17*DEF_WORD_W +: DEF_WORD_W] = mword(1'b0, 1'b1, 8'h41);
    s[18*DEF_WORD_W +: DEF_WORD_W] = mword(1'b1, 1'b0, 8'hC2);
    return s;
  endfunction

  function automatic logic [DEF_RULE_W-1:0] rule(int c, int m, int v, int t);
    return {DEF_CHAIN_W'(c), DEF_NX'(m), DEF_NX'(v), DEF_ADDR_W'(t)};
  endfunction

  // rule entry: {chain, mask, value, target}; index 0 has top priority
  function automatic logic [DEF_NRULE*DEF_RULE_W-1:0] def_rules();
    logic [DEF_NRULE*DEF_RULE_W-1:0] r;
    r = '0;
    r[0*DEF_RULE_W +: DEF_RULE_W] = rule(0, 4'h1, 4'h1, 4);
    r[1*DEF_RULE_W +: DEF_RULE_W] = rule(0, 4'h1, 4'h0, 8);
    r[2*DEF_RULE_W +: DEF_RULE_W] = rule(1, 4'h2, 4'h2, 13);
    r[3*DEF_RULE_W +: DEF_RULE_W] = rule(1, 4'h0, 4'h0, 16);
    r[4*DEF_RULE_W +: DEF_RULE_W] = rule(2, 4'h0, 4'h0, 16);
    r[5*DEF_RULE_W +: DEF_RULE_W] = rule(3, 4'hC, 4'hC, 0);
    r[6*DEF_RULE_W +: DEF_RULE_W] = rule(3, 4'h4, 4'h4, 17);
    return r;
  endfunction

endpackage

// File: rtl/cmcu_rst_sync.sv
module cmcu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_s = sh_q[1];

endmodule

// File: rtl/cmcu_ctrl_store.sv
module cmcu_ctrl_store #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 10,
  parameter logic [(1<<ADDR_W)*WORD_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = INIT[g*WORD_W +: WORD_W];
  end

  // synchronous read: word appears one edge after its address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rom[raddr];
  end

endmodule

// File: rtl/cmcu_branch.sv
module cmcu_branch #(
  parameter int CHAIN_W = 3,
  parameter int OFS_W   = 2,
  parameter int NX      = 4,
  parameter int NRULE   = 7,
  parameter logic [NRULE*(2*CHAIN_W+OFS_W+2*NX)-1:0] RULES = '0
) (
  input  logic [CHAIN_W-1:0]       chain,
  input  logic [NX-1:0]            cond,
  output logic                     hit,
  output logic [CHAIN_W+OFS_W-1:0] tgt
);

  localparam int ADDR_W = CHAIN_W + OFS_W;
  localparam int RULE_W = CHAIN_W + 2 * NX + ADDR_W;

  logic [NRULE-1:0]  hit_vec;
  logic [ADDR_W-1:0] tgt_arr [NRULE];

  for (genvar i = 0; i < NRULE; i++) begin : g_rule
    logic [RULE_W-1:0]  ent;
    logic [CHAIN_W-1:0] e_chain;
    logic [NX-1:0]      e_mask;
    logic [NX-1:0]      e_val;
    assign ent        = RULES[i*RULE_W +: RULE_W];
    assign tgt_arr[i] = ent[ADDR_W-1:0];
    assign e_val      = ent[ADDR_W +: NX];
    assign e_mask     = ent[ADDR_W+NX +: NX];
    assign e_chain    = ent[ADDR_W+2*NX +: CHAIN_W];
    assign hit_vec[i] = (e_chain == chain) && ((cond & e_mask) == (e_val & e_mask));
  end

  // lowest index wins: scan downward so the last write is the winner
  always_comb begin
    hit = 1'b0;
    tgt = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        tgt = tgt_arr[i];
      end
    end
  end

endmodule

// File: rtl/cmcu_addr_regs.sv
module cmcu_addr_regs
  import cmcu_pkg::*;
#(
  parameter int CHAIN_W = 3,
  parameter int OFS_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     stp,
  input  logic                     fin,
  input  logic                     hit,
  input  logic [CHAIN_W+OFS_W-1:0] tgt,
  output logic [CHAIN_W-1:0]       rg_q,
  output logic [OFS_W-1:0]         ct_q,
  output logic                     fetch,
  output logic                     err,
  output logic [CHAIN_W+OFS_W-1:0] nxt_addr,
  output logic                     rd_en
);

  logic [CHAIN_W-1:0] rg_d;
  logic [OFS_W-1:0]   ct_d;
  logic               tf_q, tf_d;
  logic               er_q, er_d;
  logic               ld_en;
  act_e               act;

  always_comb begin
    rg_d = rg_q;
    ct_d = ct_q;
    tf_d = tf_q;
    er_d = er_q;
    act  = ACT_HOLD;
    if (start) begin
      rg_d = '0;
      ct_d = '0;
      tf_d = 1'b1;
      er_d = 1'b0;
    end else if (tf_q) begin
      if (fin) begin
        tf_d = 1'b0;
      end else if (stp) begin
        act  = ACT_STEP;
        ct_d = ct_q + OFS_W'(1);
      end else if (hit) begin
        act          = ACT_JUMP;
        {rg_d, ct_d} = tgt;
      end else begin
        act  = ACT_TRAP;
        er_d = 1'b1;
        tf_d = 1'b0;
      end
    end
  end

  assign ld_en    = start | tf_q;
  assign nxt_addr = {rg_d, ct_d};
  assign rd_en    = start | (act == ACT_STEP) | (act == ACT_JUMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rg_q <= '0;
      ct_q <= '0;
      tf_q <= 1'b0;
      er_q <= 1'b0;
    end else if (ld_en) begin
      rg_q <= rg_d;
      ct_q <= ct_d;
      tf_q <= tf_d;
      er_q <= er_d;
    end
  end

  assign fetch = tf_q;
  assign err   = er_q;

endmodule

// File: rtl/cmcu_seq.sv
module cmcu_seq
  import cmcu_pkg::*;
#(
  parameter int CHAIN_W = DEF_CHAIN_W,
  parameter int OFS_W   = DEF_OFS_W,
  parameter int NX      = DEF_NX,
  parameter int NY      = DEF_NY,
  parameter int NRULE   = DEF_NRULE,
  parameter logic [(1<<(CHAIN_W+OFS_W))*(NY+2)-1:0] STORE_INIT = def_store(),
  parameter logic [NRULE*(2*CHAIN_W+OFS_W+2*NX)-1:0] RULES    = def_rules()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NX-1:0] cond,
  output logic          fetch,
  output logic          err,
  output logic [NY-1:0] uops
);

  localparam int ADDR_W = CHAIN_W + OFS_W;
  localparam int WORD_W = NY + 2;

  logic               rst_n_s;
  logic [CHAIN_W-1:0] rg_q;
  logic [OFS_W-1:0]   ct_q;
  logic [ADDR_W-1:0]  nxt_addr;
  logic [ADDR_W-1:0]  tgt;
  logic               hit;
  logic               rd_en;
  logic [WORD_W-1:0]  mi_q;
  logic               mi_y0;
  logic               mi_ye;

  cmcu_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  cmcu_branch #(
    .CHAIN_W (CHAIN_W),
    .OFS_W   (OFS_W),
    .NX      (NX),
    .NRULE   (NRULE),
    .RULES   (RULES)
  ) u_br (
    .chain (rg_q),
    .cond  (cond),
    .hit   (hit),
    .tgt   (tgt)
  );

  cmcu_addr_regs #(
    .CHAIN_W (CHAIN_W),
    .OFS_W   (OFS_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .stp      (mi_y0),
    .fin      (mi_ye),
    .hit      (hit),
    .tgt      (tgt),
    .rg_q     (rg_q),
    .ct_q     (ct_q),
    .fetch    (fetch),
    .err      (err),
    .nxt_addr (nxt_addr),
    .rd_en    (rd_en)
  );

  cmcu_ctrl_store #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .INIT   (STORE_INIT)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n_s),
    .rd_en (rd_en),
    .raddr (nxt_addr),
    .rdata (mi_q)
  );

  assign mi_y0 = mi_q[NY];
  assign mi_ye = mi_q[NY+1];
  assign uops  = fetch ? mi_q[NY-1:0] : '0;

endmodule

// File: rtl/cmcu_seq_chk.sv
module cmcu_seq_chk #(
  parameter int CHAIN_W = 3,
  parameter int OFS_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               fetch,
  input logic               err,
  input logic [CHAIN_W-1:0] rg,
  input logic [OFS_W-1:0]   ct,
  input logic               y0,
  input logic               ye
);

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (fetch && !err && rg == '0 && ct == '0));

  p_step_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !start && y0 && !ye) |=> (ct == OFS_W'($past(ct) + 1'b1) && $stable(rg)));

  p_end_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && ye && !start) |=> !fetch);

  p_idle_stay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch && !start) |=> !fetch);

  p_trap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> (err && !fetch && $stable(rg) && $stable(ct)));

endmodule

bind cmcu_seq cmcu_seq_chk #(
  .CHAIN_W (CHAIN_W),
  .OFS_W   (OFS_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .start (start),
  .fetch (fetch),
  .err   (err),
  .rg    (rg_q),
  .ct    (ct_q),
  .y0    (mi_y0),
  .ye    (mi_ye)
);

// File: tb/sim_cmcu_seq.sv
`timescale 1ns/1ps
module sim_cmcu_seq;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] cond;
  logic       fetch;
  logic       err;
  logic [7:0] uops;

  int total = 0;
  int bad   = 0;

  cmcu_seq u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cond  (cond),
    .fetch (fetch),
    .err   (err),
    .uops  (uops)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // row: {start, cond, exp fetch, exp err, exp uops}
  function automatic logic [14:0] v(logic s, logic [3:0] x, logic f, logic e, logic [7:0] y);
    return {s, x, f, e, y};
  endfunction

  localparam int NV = 64;
  localparam logic [14:0] VEC [NV] = '{
    // run A, cond=0001: chain0 -> chain1 -> chain4 -> stop
    v(1,4'h1,1,0,8'h01), v(0,4'h1,1,0,8'h02), v(0,4'h1,1,0,8'h03), v(0,4'h1,1,0,8'h10),
    v(0,4'h1,1,0,8'h11), v(0,4'h1,1,0,8'h12), v(0,4'h1,1,0,8'h13), v(0,4'h1,1,0,8'h40),
    v(0,4'h1,1,0,8'h41), v(0,4'h1,1,0,8'hC2), v(0,4'h1,0,0,8'h00),
    // run B, cond=0000: chain0 -> chain2 -> chain4
    v(1,4'h0,1,0,8'h01), v(0,4'h0,1,0,8'h02), v(0,4'h0,1,0,8'h03), v(0,4'h0,1,0,8'h20),
    v(0,4'h0,1,0,8'h21), v(0,4'h0,1,0,8'h40), v(0,4'h0,1,0,8'h41), v(0,4'h0,1,0,8'hC2),
    v(0,4'h0,0,0,8'h00),
    // run C, cond=0011: mid-chain entry into chain3, then no rule matches
    v(1,4'h3,1,0,8'h01), v(0,4'h3,1,0,8'h02), v(0,4'h3,1,0,8'h03), v(0,4'h3,1,0,8'h10),
    v(0,4'h3,1,0,8'h11), v(0,4'h3,1,0,8'h12), v(0,4'h3,1,0,8'h13), v(0,4'h3,1,0,8'h31),
    v(0,4'h3,1,0,8'h32), v(0,4'h3,0,1,8'h00), v(0,4'h3,0,1,8'h00),
    // run D, cond=1111: two rules match at chain3, lower index loops to chain0
    v(1,4'hF,1,0,8'h01), v(0,4'hF,1,0,8'h02), v(0,4'hF,1,0,8'h03), v(0,4'hF,1,0,8'h10),
    v(0,4'hF,1,0,8'h11), v(0,4'hF,1,0,8'h12), v(0,4'hF,1,0,8'h13), v(0,4'hF,1,0,8'h31),
    v(0,4'hF,1,0,8'h32), v(0,4'hF,1,0,8'h01), v(0,4'hF,1,0,8'h02), v(0,4'h0,1,0,8'h03),
    v(0,4'h0,1,0,8'h20), v(0,4'h0,1,0,8'h21), v(0,4'h0,1,0,8'h40), v(0,4'h0,1,0,8'h41),
    v(0,4'h0,1,0,8'hC2), v(0,4'h0,0,0,8'h00),
    // run E, cond=0111: second chain3 rule enters chain4 at offset 1
    v(1,4'h7,1,0,8'h01), v(0,4'h7,1,0,8'h02), v(0,4'h7,1,0,8'h03), v(0,4'h7,1,0,8'h10),
    v(0,4'h7,1,0,8'h11), v(0,4'h7,1,0,8'h12), v(0,4'h7,1,0,8'h13), v(0,4'h7,1,0,8'h31),
    v(0,4'h7,1,0,8'h32), v(0,4'h7,1,0,8'h41), v(0,4'h7,1,0,8'hC2), v(0,4'h7,0,0,8'h00),
    // restart while running
    v(1,4'h1,1,0,8'h01), v(0,4'h1,1,0,8'h02), v(1,4'h1,1,0,8'h01)
  };

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {fetch,err,uops} actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cond  = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {fetch, err, uops}, 10'h000);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 R7 after reset", {fetch, err, uops}, 10'h000);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      start = VEC[i][14];
      cond  = VEC[i][13:10];
      step();
      check($sformatf("row %0d R2 R3 R4 R5 R6 R7 R8 R9 R10", i),
            {fetch, err, uops}, VEC[i][9:0]);
    end

    // reset in the middle of a run clears everything at once
    start = 1'b0;
    @(posedge clk);
    #5;
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid-run", {fetch, err, uops}, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cond = 4'(k * 5);
      step();
    end
    check("R6 R7 idle without start", {fetch, err, uops}, 10'h000);

    // start held for two edges keeps re-entering address 0
    cond  = 4'h0;
    start = 1'b1;
    step();
    check("R2 start first edge", {fetch, err, uops}, 10'h201);
    step();
    check("R2 start held", {fetch, err, uops}, 10'h201);
    start = 1'b0;
    step();
    check("R3 step after start", {fetch, err, uops}, 10'h202);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule